// File: doc/BRIEF.md
# Tone Steering and Digit Latch

This block sits behind a dual-tone detector and decides when a detected key press counts as a digit. The detector supplies a "tone pair present" level and a 4-bit key code. The block passes the presence level straight out as an early-steering signal. It also drives a guard-time output that charges or drains a digital steering integrator, which stands in for an external RC network. The integrator is read through a hysteresis comparator with programmable upper and lower thresholds, and the comparator result is the steering level `st`.

On each rising transition of `st`, the current key code is captured into the receive register and a ready flag is raised toward the bus side. The flag stays set until the host acknowledges it. A steering level that stays high through a short dropout does not register the digit a second time. A tone too short to reach the upper threshold is never registered.

Top module: `dtmf_steer`

## Requirements
- R1: `est` equals `tone_valid` in the same cycle, with no register in the path, so it rises on detection and drops at once on any loss.
- R2: `gt` is high exactly while `est` is high.
- R3: The integrator count starts at 0. It rises by one per clock while `gt` is high and saturates at 2^CW-1. It falls by one per clock while `gt` is low and stops at 0. `st` is set on the first edge at which the count before the edge is at least `up_th`, so from an empty integrator `st` rises on edge `up_th`+1 of a tone.
- R4: `st` clears on the first edge at which the count before the edge is at most `dn_th`. Otherwise `st` holds its value.
- R5: On the edge where `st` goes from 0 to 1, `rx_code` takes the value of `tone_code` and `rx_ready` is set.
- R6: `rx_code` changes only on a rising transition of `st`. A dropout that leaves `st` high causes no second registration.
- R7: `rx_ack` high at an edge clears `rx_ready` at that edge, unless a new registration happens at the same edge.
- R8: After reset, `st`, `rx_ready`, `rx_code` and the integrator count are all 0.
- R9: A tone lasting fewer than `up_th` edges, starting from an empty integrator, never sets `st` or `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tone_valid | input | 1 | Detector reports a valid tone pair |
| tone_code | input | 4 | Detector key code |
| up_th | input | CW | Integrator level that sets `st` |
| dn_th | input | CW | Integrator level that clears `st` |
| rx_ack | input | 1 | Host acknowledge, clears the ready flag |
| est | output | 1 | Early steering, follows the detector |
| gt | output | 1 | Guard-time drive to the integrator |
| st | output | 1 | Steering level after the hysteresis comparator |
| rx_code | output | 4 | Latched key code |
| rx_ready | output | 1 | A digit has been registered and not yet acknowledged |

## Verification
A wrong integrator count shows up as `st` rising or falling on the wrong edge. The bench measures that edge index against `up_th`+1 after tone start and against burst length minus `dn_th` plus one after tone end, so an off-by-one error is exposed within a single burst. A faulty capture or flag path shows as a wrong `rx_code` or a missing or extra `rx_ready` on the very edge where `st` rises. A repeat registration is caught after a dropout, once the host has acknowledged the first digit.

// File: rtl/dtmf_steer.sv
module dtmf_steer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tone_valid,
  input  logic [3:0]    tone_code,
  input  logic [CW-1:0] up_th,
  input  logic [CW-1:0] dn_th,
  input  logic          rx_ack,
  output logic          est,
  output logic          gt,
  output logic          st,
  output logic [3:0]    rx_code,
  output logic          rx_ready
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;
  logic          st_nxt, st_rise;

  assign est     = tone_valid;
  assign gt      = est;
  assign st_nxt  = st ? (cnt > dn_th) : (cnt >= up_th);
  assign st_rise = st_nxt & ~st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      st  <= 1'b0;
    end else begin
      st <= st_nxt;
      if (gt) cnt <= (cnt == CMAX) ? cnt : cnt + 1'b1;
      else    cnt <= (cnt == '0)   ? cnt : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_code  <= '0;
      rx_ready <= 1'b0;
    end else if (st_rise) begin
      rx_code  <= tone_code;
      rx_ready <= 1'b1;
    end else if (rx_ack) begin
      rx_ready <= 1'b0;
    end
  end

  p_set_above_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st) |-> $past(cnt) >= $past(up_th));

  p_clear_below_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st) |-> $past(cnt) <= $past(dn_th));

  p_ready_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st) |-> rx_ready);

  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(st) |-> $stable(rx_code));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_ack) && !$rose(st)) |-> !rx_ready);

  p_gt_est_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gt == tone_valid);
endmodule

// File: tb/dtmf_steer_test.sv
module dtmf_steer_test;
  localparam int CW = 6;
  logic clk = 0, rst_n = 0, tone_valid = 0, rx_ack = 0;
  logic [3:0] tone_code = 0;
  logic [CW-1:0] up_th = 2, dn_th = 1;
  logic est, gt, st, rx_ready;
  logic [3:0] rx_code;
  int total = 0, bad = 0;

  dtmf_steer #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tone_valid(tone_valid), .tone_code(tone_code),
    .up_th(up_th), .dn_th(dn_th), .rx_ack(rx_ack), .est(est), .gt(gt),
    .st(st), .rx_code(rx_code), .rx_ready(rx_ready));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ack_check();
    @(negedge clk) rx_ack = 1;
    @(negedge clk) rx_ack = 0;
    chk(rx_ready == 0, "R7 ack clears ready", rx_ready, 0);
  endtask

  task automatic burst(input logic [3:0] c, input int len, input int up, input int dn);
    int rise = -1, fall = -1, exp_rise;
    @(negedge clk);
    up_th = CW'(up); dn_th = CW'(dn);
    tone_valid = 1; tone_code = c;
    #1 chk(est == 1, "R1 est on", est, 1);
    chk(gt == 1, "R2 gt on", gt, 1);
    for (int k = 1; k <= len; k++) begin
      @(posedge clk); #1;
      if (st && rise < 0) rise = k;
    end
    @(negedge clk) tone_valid = 0;
    #1 chk(est == 0, "R1 est off", est, 0);
    chk(gt == 0, "R2 gt off", gt, 0);
    exp_rise = (len >= up + 1) ? up + 1 : -1;
    if (exp_rise < 0) begin
      for (int j = 1; j <= 80; j++) begin
        @(posedge clk); #1;
        if (st) rise = len + j;
      end
      chk(rise < 0, "R9 short tone no steering", rise, -1);
      chk(rx_ready == 0, "R9 short tone no ready", rx_ready, 0);
    end else begin
      chk(rise == exp_rise, "R3 st rise edge", rise, exp_rise);
      chk(rx_code == c, "R5 captured code", rx_code, c);
      chk(rx_ready == 1, "R5 ready set", rx_ready, 1);
      for (int j = 1; j <= 80; j++) begin
        @(posedge clk); #1;
        if (!st && fall < 0) fall = j;
      end
      begin
        int lvl = (len > 63) ? 63 : len;
        chk(fall == lvl - dn + 1, "R4 st fall edge", fall, lvl - dn + 1);
      end
    end
    ack_check();
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 chk(st == 0 && rx_ready == 0 && rx_code == 0, "R8 reset state",
           {st, rx_ready, rx_code}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R3 R4 R5: sweep thresholds with hysteresis
    for (int up = 1; up <= 6; up++)
      for (int dn = 0; dn < up; dn++)
        burst(4'((up * 7 + dn) % 16), up + 1 + ((up + dn) % 8), up, dn);
    // R5: every key code
    for (int c = 0; c < 16; c++) burst(4'(c), 5, 2, 1);
    // R9: tones too short
    for (int up = 2; up <= 6; up++) burst(4'(up), up - 1, up, 0);
    // R3: saturation at 63
    burst(4'd9, 70, 2, 1);
    // R6: dropout keeps st high, no second registration
    begin
      bit st_low = 0;
      @(negedge clk);
      up_th = 3; dn_th = 1; tone_valid = 1; tone_code = 4'd5;
      repeat (12) @(negedge clk);
      chk(rx_code == 5 && rx_ready == 1, "R6 first registration", rx_code, 5);
      rx_ack = 1;
      @(negedge clk) rx_ack = 0;
      tone_valid = 0; tone_code = 4'd10;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (!st) st_low = 1;
      end
      tone_valid = 1;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (!st) st_low = 1;
      end
      chk(!st_low, "R6 st held through dropout", st_low, 0);
      chk(rx_ready == 0, "R6 no second ready", rx_ready, 0);
      chk(rx_code == 5, "R6 code unchanged", rx_code, 5);
      tone_valid = 0;
      repeat (40) @(negedge clk);
      chk(st == 0, "R4 st released after drain", st, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule